// File: doc/BRIEF.md
# Half-Warp Load Coalescer

The block takes one load request for a half-warp: sixteen byte addresses, each for a 4-byte word, and a bit per lane that says whether the lane takes part. It groups the lanes by the aligned 64-byte memory segment their addresses fall in. It then issues one memory transaction per distinct segment. Each transaction carries the segment base and the mask of lanes it serves. Transactions leave one at a time over a valid/ready handshake. After the last transaction the block pulses a completion signal and becomes ready for the next half-warp.

The number of transactions depends only on how many different segments the qualifying lanes touch. It does not depend on how many lanes are active or on the order of their addresses. An active lane whose address is not a multiple of four takes no part in any transaction, and the block reports it on an error mask.

Top module: `coal_half_warp`

## Requirements
- R1: `req_ready` is 1 only while no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the cycle after the completion pulse.
- R2: A lane qualifies when its `req_active` bit is 1 and bits [1:0] of its address are zero. Lane i occupies `req_addr[32*i+31:32*i]`.
- R3: From the cycle after a request is taken, bit i of `misalign_err` is 1 exactly when lane i is active and misaligned. The mask holds until the next request is taken. A flagged lane never appears in any `txn_mask`.
- R4: Each transaction's `txn_base` is a lane address with bits [5:0] cleared. `txn_mask` holds every qualifying lane whose address lies in that 64-byte segment.
- R5: The number of transactions per request equals the number of distinct segments among the qualifying lanes. This count is 1 for any permutation of addresses inside one segment, and 0 when no lane qualifies.
- R6: Transactions are issued in ascending order of the lowest-numbered lane that touches each segment.
- R7: While `txn_valid` is 1 and `txn_ready` is 0, the next cycle keeps `txn_valid` at 1 and keeps `txn_base` and `txn_mask` unchanged.
- R8: `batch_done` is a one-cycle pulse with `txn_valid` low. It comes in the cycle after the last transaction handshake, or in the cycle after acceptance when no lane qualifies.
- R9: The masks of one request do not overlap, and together they cover exactly the qualifying lanes.
- R10: After reset, `req_ready` is 1, `txn_valid` and `batch_done` are 0, and `misalign_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Half-warp request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 512 | Sixteen 32-bit lane byte addresses, lane 0 in the low bits |
| req_active | input | 16 | Per-lane participation bits |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_base | output | 32 | 64-byte aligned segment address |
| txn_mask | output | 16 | Lanes served by this transaction |
| batch_done | output | 1 | Request finished pulse |
| misalign_err | output | 16 | Active lanes with a non-word-aligned address |

## Verification
Directed patterns cover the following cases:
- Sequential and permuted word addresses inside one segment, which must both give a single transaction.
- A sequence offset by one word with only part of the lanes active, which stays in one segment.
- A full sequence offset by one word, which crosses into a second segment.
- Sixteen lanes in sixteen separate segments, the longest issue stream.
- An all-idle request and byte-misaligned lanes, which test the empty and error paths.

Random requests draw lane addresses from a small pool of segments and mix in a few misaligned lanes. `txn_ready` is randomized throughout, so issue order, mask grouping and holding under back-pressure are all checked against a bench model on many different groupings.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} coal_state_e;
endpackage

// File: rtl/coal_qualify.sv
module coal_qualify #(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 4
) (
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES-1:0]        lane_active,
  output logic [LANES-1:0]        ok_mask,
  output logic [LANES-1:0]        bad_mask
);
  localparam int ELEM_SHIFT = $clog2(ELEM_BYTES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic aligned;
    assign aligned     = (lane_addr[g*ADDR_W +: ELEM_SHIFT] == '0);
    assign ok_mask[g]  = lane_active[g] & aligned;
    assign bad_mask[g] = lane_active[g] & ~aligned;
  end
endmodule

// File: rtl/coal_seg_pick.sv
module coal_seg_pick #(
  parameter int LANES     = 16,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 64
) (
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES-1:0]        pending,
  output logic                    any_pending,
  output logic [ADDR_W-1:0]       seg_base,
  output logic [LANES-1:0]        seg_mask
);
  localparam int SEG_SHIFT = $clog2(SEG_BYTES);
  localparam int IDX_W     = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDX_W-1:0]  lead_idx;
  logic [ADDR_W-1:0] lead_addr;

  // lowest pending lane leads the next segment
  always_comb begin
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) lead_idx = IDX_W'(i);
    end
  end

  assign any_pending = |pending;
  assign lead_addr   = lane_addr[lead_idx*ADDR_W +: ADDR_W];
  assign seg_base    = {lead_addr[ADDR_W-1:SEG_SHIFT], {SEG_SHIFT{1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign seg_mask[g] = pending[g] &
      (lane_addr[g*ADDR_W+SEG_SHIFT +: ADDR_W-SEG_SHIFT] == lead_addr[ADDR_W-1:SEG_SHIFT]);
  end
endmodule

// File: rtl/coal_half_warp.sv
module coal_half_warp
  import coal_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int SEG_BYTES  = 64,
  parameter int ELEM_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_active,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_base,
  output logic [LANES-1:0]        txn_mask,
  output logic                    batch_done,
  output logic [LANES-1:0]        misalign_err
);
  localparam int AW_ALL = LANES * ADDR_W;

  coal_state_e       state_q, state_d;
  logic [AW_ALL-1:0] addr_q;
  logic [LANES-1:0]  pend_q, pend_d;
  logic [LANES-1:0]  err_q;
  logic [LANES-1:0]  ok_mask, bad_mask;
  logic              any_pend;
  logic [ADDR_W-1:0] pick_base;
  logic [LANES-1:0]  pick_mask;
  logic              load_en, pop_en, pend_en;

  coal_qualify #(.LANES(LANES), .ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES)) u_qual (
    .lane_addr   (req_addr),
    .lane_active (req_active),
    .ok_mask     (ok_mask),
    .bad_mask    (bad_mask)
  );

  coal_seg_pick #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) u_pick (
    .lane_addr   (addr_q),
    .pending     (pend_q),
    .any_pending (any_pend),
    .seg_base    (pick_base),
    .seg_mask    (pick_mask)
  );

  assign req_ready    = (state_q == ST_IDLE);
  assign txn_valid    = (state_q == ST_BUSY) & any_pend;
  assign batch_done   = (state_q == ST_BUSY) & ~any_pend;
  assign txn_base     = pick_base;
  assign txn_mask     = pick_mask;
  assign misalign_err = err_q;

  assign load_en = req_valid & req_ready;
  assign pop_en  = txn_valid & txn_ready;
  assign pend_en = load_en | pop_en;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    if (load_en) begin
      state_d = ST_BUSY;
      pend_d  = ok_mask;
    end else if (pop_en) begin
      pend_d  = pend_q & ~pick_mask;
    end else if (batch_done) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      err_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pend_en) pend_q <= pend_d;
      if (load_en) begin
        err_q  <= bad_mask;
        addr_q <= req_addr;
      end
    end
  end
endmodule

// File: rtl/coal_half_warp_chk.sv
module coal_half_warp_chk #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  parameter int SEG_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_base,
  input logic [LANES-1:0]  txn_mask,
  input logic              batch_done,
  input logic [LANES-1:0]  misalign_err
);
  localparam int SEG_SHIFT = $clog2(SEG_BYTES);

  logic [LANES-1:0] issued_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued_q <= '0;
    else if (req_valid && req_ready) issued_q <= '0;
    else if (txn_valid && txn_ready) issued_q <= issued_q | txn_mask;
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_mask)));

  a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_base[SEG_SHIFT-1:0] == '0));

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid || batch_done) |-> !req_ready);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> (!txn_valid && $past(!batch_done)));

  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |=> req_ready);

  a_r3_err_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & misalign_err) == '0));

  a_r9_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & issued_q) == '0) && (txn_mask != '0));
endmodule

bind coal_half_warp coal_half_warp_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .txn_valid    (txn_valid),
  .txn_ready    (txn_ready),
  .txn_base     (txn_base),
  .txn_mask     (txn_mask),
  .batch_done   (batch_done),
  .misalign_err (misalign_err)
);

// File: tb/coal_half_warp_tb.sv
module coal_half_warp_tb;
  localparam int L = 16;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [L*AW-1:0] req_addr = '0;
  logic [L-1:0]  req_active = '0;
  logic          txn_valid;
  logic          txn_ready = 1'b0;
  logic [AW-1:0] txn_base;
  logic [L-1:0]  txn_mask;
  logic          batch_done;
  logic [L-1:0]  misalign_err;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] a [L];
  logic [L-1:0]  act;
  logic [AW-1:0] exp_base [L];
  logic [L-1:0]  exp_mask [L];
  logic [L-1:0]  exp_err;
  int            exp_n;
  int            ready_pct;

  always #4 clk = ~clk;

  coal_half_warp u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_active(req_active), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_base(txn_base), .txn_mask(txn_mask),
    .batch_done(batch_done), .misalign_err(misalign_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // reference grouping from the requirements (R2, R4, R5, R6)
  task automatic build_expect();
    logic [L-1:0] pend;
    exp_n = 0;
    exp_err = '0;
    pend = '0;
    for (int i = 0; i < L; i++) begin
      if (act[i] && a[i][1:0] == 2'b00) pend[i] = 1'b1;
      if (act[i] && a[i][1:0] != 2'b00) exp_err[i] = 1'b1;
    end
    while (pend != '0) begin
      int lead;
      lead = -1;
      for (int i = 0; i < L; i++) if (pend[i] && lead < 0) lead = i;
      exp_base[exp_n] = {a[lead][AW-1:6], 6'b0};
      exp_mask[exp_n] = '0;
      for (int i = 0; i < L; i++)
        if (pend[i] && a[i][AW-1:6] == a[lead][AW-1:6]) exp_mask[exp_n][i] = 1'b1;
      pend = pend & ~exp_mask[exp_n];
      exp_n++;
    end
  endtask

  task automatic run_case(input string name);
    int got_n;
    int guard;
    bit held;
    logic [AW-1:0] h_base;
    logic [L-1:0]  h_mask;
    logic [L-1:0]  seen;
    build_expect();
    @(negedge clk);
    check(req_ready == 1'b1, "R1 idle ready", 64'(req_ready), 64'd1);
    for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = a[i];
    req_active = act;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1 busy not ready", 64'(req_ready), 64'd0);
    check(misalign_err == exp_err, "R3 error mask", 64'(misalign_err), 64'(exp_err));
    got_n = 0; guard = 0; held = 1'b0; seen = '0;
    while (!batch_done && guard < 400) begin
      if (held) begin
        check(txn_valid && txn_base == h_base && txn_mask == h_mask, "R7 hold",
              {txn_base, 16'(txn_mask), 16'(txn_valid)}, {h_base, 16'(h_mask), 16'd1});
        held = 1'b0;
      end
      txn_ready = ($urandom_range(99) < ready_pct);
      if (txn_valid && txn_ready) begin
        if (got_n < exp_n) begin
          check(txn_base == exp_base[got_n], "R4/R6 base", 64'(txn_base), 64'(exp_base[got_n]));
          check(txn_mask == exp_mask[got_n], "R4/R6 mask", 64'(txn_mask), 64'(exp_mask[got_n]));
        end
        seen = seen | txn_mask;
        got_n++;
      end else if (txn_valid) begin
        held = 1'b1; h_base = txn_base; h_mask = txn_mask;
      end
      @(negedge clk);
      guard++;
    end
    txn_ready = 1'b0;
    check(batch_done && !txn_valid, {"R8 done pulse ", name}, 64'(batch_done), 64'd1);
    check(got_n == exp_n, {"R5 count ", name}, 64'(got_n), 64'(exp_n));
    check((seen & exp_err) == '0, "R9 cover/R3 excluded", 64'(seen), 64'(~exp_err & act));
    @(negedge clk);
    check(!batch_done && req_ready, "R8 single pulse / R1 ready again",
          {63'd0, batch_done}, 64'd0);
    check(misalign_err == exp_err, "R3 error held", 64'(misalign_err), 64'(exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    ready_pct = 60;
    #1;
    check(req_ready == 1'b1 && !txn_valid && !batch_done && misalign_err == '0,
          "R10 reset state", {req_ready, txn_valid, batch_done}, 64'd4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // sequential in one segment
    for (int i = 0; i < L; i++) a[i] = 32'h0000_1000 + 32'(4*i);
    act = '1; run_case("seq");
    // permuted in one segment
    for (int i = 0; i < L; i++) a[i] = 32'h0000_2040 + 32'(4*((i*7+3) % L));
    act = '1; run_case("perm");
    // word offset, half lanes active, stays in one segment (R5)
    for (int i = 0; i < L; i++) a[i] = 32'h0000_3004 + 32'(4*i);
    act = 16'h00FF; run_case("off_one");
    // word offset, all lanes, crosses boundary (R5: two)
    act = '1; run_case("off_two");
    // every lane in its own segment, reverse order (R6)
    for (int i = 0; i < L; i++) a[i] = 32'h0001_0000 + 32'(64*(L-1-i));
    act = '1; run_case("spread");
    // no lane active
    act = '0; run_case("empty");
    // byte-misaligned lanes (R2, R3)
    for (int i = 0; i < L; i++) a[i] = 32'h0000_4000 + 32'(4*i) + ((i % 3 == 0) ? 32'd1 : 32'd0);
    act = '1; run_case("misalign");
    // all active lanes misaligned
    for (int i = 0; i < L; i++) a[i] = 32'h0000_5002 + 32'(4*i);
    act = 16'hA5A5; run_case("all_bad");

    ready_pct = 45;
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] pool [4];
      for (int k = 0; k < 4; k++) pool[k] = {$urandom_range(32'h3FF_FFFF), 6'b0};
      for (int i = 0; i < L; i++) begin
        a[i] = pool[$urandom_range(3)] + 32'(4*$urandom_range(15));
        if ($urandom_range(15) == 0) a[i] = a[i] + 32'($urandom_range(1, 3));
      end
      act = 16'($urandom);
      run_case("rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule